// File: doc/BRIEF.md
# Compressed-Extension Alignment CSR Unit

This unit keeps the ISA-extension register and the three saved exception program counters (machine, supervisor and debug). It enforces the instruction alignment that follows from whether the compressed extension is on. When compressed instructions are enabled, any even address is a legal instruction address. When they are disabled, instructions must sit on 4-byte boundaries. The unit turns that choice into an alignment mask that the rest of the core uses.

Software reaches the registers through a simple CSR port: address, write enable, write data and combinational read data. A trap-entry port loads one chosen EPC with the faulting PC. Three outputs serve the core. The first is the mask itself. The second is a masked copy of the target of a serializing control transfer. The third flags a candidate fetch address that breaks the current alignment.

The stored EPC values are never rewritten when the alignment changes. Only the view that software reads through the CSR port is masked. A write that would turn off compressed instructions while the current PC sits on a 2-byte boundary is refused as a whole.

Top module: `ext_align_csr`

## Requirements
- R1: After reset the ISA register reads back `RESET_ISA`, which has bit 2 set by default (0x4014112D for 32 bits), and all three EPCs read zero.
- R2: `alignMask` is all ones while ISA bit 2 (compressed enable) is set; otherwise it is all ones except bit 1.
- R3: A write to the ISA register whose data has bit 2 clear is dropped entirely, leaving every ISA bit unchanged, when `curPc[1]` is 1.
- R4: An accepted ISA write stores the written value, except that bit 3 (double float) is stored as 0 whenever bit 5 (single float) of the written value is 0.
- R5: Reads of the machine EPC, supervisor EPC and debug PC return the stored value ANDed with `alignMask`, so bit 1 hidden while compressed is off becomes visible again once it is re-enabled.
- R6: A CSR write to any EPC stores the written data with bit 0 forced to 0.
- R7: When `trapValid` is 1, the EPC chosen by `trapSel` (0 machine, 1 supervisor, 2 debug, 3 none) is loaded with `trapPc` with bit 0 cleared on the next clock, and this wins over a CSR write to the same EPC in that cycle.
- R8: `jumpPcMasked` equals `jumpPc` ANDed with `alignMask`.
- R9: `candMisaligned` is 1 exactly when `candPc` has a bit set where `alignMask` is 0.
- R10: CSR addresses other than the four mapped ones read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csrAddr | input | ADDR_W | CSR address |
| csrWe | input | 1 | CSR write enable |
| csrWdata | input | XLEN | CSR write data |
| csrRdata | output | XLEN | CSR read data (combinational) |
| curPc | input | XLEN | PC of the instruction currently performing the CSR access |
| trapValid | input | 1 | Trap entry strobe |
| trapSel | input | 2 | EPC to load on trap: 0 machine, 1 supervisor, 2 debug |
| trapPc | input | XLEN | PC saved on trap entry |
| jumpPc | input | XLEN | Target of a serializing control transfer |
| jumpPcMasked | output | XLEN | Target after alignment masking |
| candPc | input | XLEN | Candidate fetch address |
| candMisaligned | output | 1 | Candidate address violates current alignment |
| alignMask | output | XLEN | Current instruction alignment mask |

## Verification
The bench tries to disable compressed instructions while the PC sits on a 2-byte boundary. A design that ignored the guard would switch the mask and leave fetch stranded. A design that filtered only bit 2 would still let the other ISA bits change. The bench hides EPC bit 1 and then re-enables compressed instructions. A design that cleared the stored bit instead of masking on read would lose it for good. The bench also issues a trap load and a CSR write to the same EPC in one cycle. A design with the wrong priority would keep the software value. Finally, it writes the ISA register with single float off and double float on, to catch a design that stores the illegal combination.

// File: rtl/ext_align_pkg.sv
package ext_align_pkg;

  localparam int NUM_EPC = 3;
  localparam int EPC_M   = 0;
  localparam int EPC_S   = 1;
  localparam int EPC_D   = 2;

  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
  localparam int BIT_F = 5;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ISA,
    RD_MEPC,
    RD_SEPC,
    RD_DPC
  } rd_sel_e;

  typedef struct packed {
    logic                isaHit;
    logic                wrIsa;
    logic [NUM_EPC-1:0]  wrEpc;
    logic [NUM_EPC-1:0]  ldEpc;
    rd_sel_e             rdSel;
  } csr_strobe_t;

endpackage

// File: rtl/ext_align_ctrl.sv
module ext_align_ctrl
  import ext_align_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [11:0]     ADDR_ISA  = 12'h301,
  parameter logic [11:0]     ADDR_MEPC = 12'h341,
  parameter logic [11:0]     ADDR_SEPC = 12'h141,
  parameter logic [11:0]     ADDR_DPC  = 12'h7B1
) (
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWe,
  input  logic              wdataCompressed,
  input  logic              curPcBit1,
  input  logic              trapValid,
  input  logic [1:0]        trapSel,
  output csr_strobe_t       strobes
);

  localparam logic [ADDR_W-1:0] A_ISA  = ADDR_W'(ADDR_ISA);
  localparam logic [ADDR_W-1:0] A_MEPC = ADDR_W'(ADDR_MEPC);
  localparam logic [ADDR_W-1:0] A_SEPC = ADDR_W'(ADDR_SEPC);
  localparam logic [ADDR_W-1:0] A_DPC  = ADDR_W'(ADDR_DPC);

  logic hitIsa, hitMepc, hitSepc, hitDpc;
  logic isaWriteSafe;

  assign hitIsa  = (csrAddr == A_ISA);
  assign hitMepc = (csrAddr == A_MEPC);
  assign hitSepc = (csrAddr == A_SEPC);
  assign hitDpc  = (csrAddr == A_DPC);

  // Clearing the compressed enable is only safe on a 4-byte aligned PC
  assign isaWriteSafe = wdataCompressed || !curPcBit1;

  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    strobes.isaHit = csrWe && hitIsa;
    strobes.wrIsa  = csrWe && hitIsa && isaWriteSafe;
    strobes.wrEpc[EPC_M] = csrWe && hitMepc;
    strobes.wrEpc[EPC_S] = csrWe && hitSepc;
    strobes.wrEpc[EPC_D] = csrWe && hitDpc;
    for (int i = 0; i < NUM_EPC; i++) begin
      strobes.ldEpc[i] = trapValid && (int'(trapSel) == i);
    end
    if (hitIsa)       strobes.rdSel = RD_ISA;
    else if (hitMepc) strobes.rdSel = RD_MEPC;
    else if (hitSepc) strobes.rdSel = RD_SEPC;
    else if (hitDpc)  strobes.rdSel = RD_DPC;
  end

endmodule

// File: rtl/ext_align_dp.sv
module ext_align_dp
  import ext_align_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter logic [XLEN-1:0]  RESET_ISA = XLEN'(32'h4014112D)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  csr_strobe_t     strobes,
  input  logic [XLEN-1:0] csrWdata,
  input  logic            curPcBit1,
  input  logic [XLEN-1:0] trapPc,
  input  logic [XLEN-1:0] jumpPc,
  input  logic [XLEN-1:0] candPc,
  output logic [XLEN-1:0] csrRdata,
  output logic [XLEN-1:0] alignMask,
  output logic [XLEN-1:0] jumpPcMasked,
  output logic            candMisaligned
);

  localparam logic [XLEN-1:0] HALF_WORD_BIT = XLEN'(2);

  logic [XLEN-1:0] isaQ;
  logic [XLEN-1:0] isaNext;
  logic [NUM_EPC-1:0][XLEN-1:0] epcQ;

  // Double float cannot be kept without single float
  always_comb begin
    isaNext = csrWdata;
    if (!csrWdata[BIT_F]) isaNext[BIT_D] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             isaQ <= RESET_ISA;
    else if (strobes.wrIsa) isaQ <= isaNext;
  end

  assign alignMask      = isaQ[BIT_C] ? '1 : ~HALF_WORD_BIT;
  assign jumpPcMasked   = jumpPc & alignMask;
  assign candMisaligned = |(candPc & ~alignMask);

  for (genvar g = 0; g < NUM_EPC; g++) begin : g_epc
    logic [XLEN-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rst_n)                slotQ <= '0;
      else if (strobes.ldEpc[g]) slotQ <= {trapPc[XLEN-1:1], 1'b0};
      else if (strobes.wrEpc[g]) slotQ <= {csrWdata[XLEN-1:1], 1'b0};
    end
    assign epcQ[g] = slotQ;

    assert_trap_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.ldEpc[g] |=> (slotQ == ($past(trapPc) & ~XLEN'(1))));
  end

  always_comb begin
    case (strobes.rdSel)
      RD_ISA:  csrRdata = isaQ;
      RD_MEPC: csrRdata = epcQ[EPC_M] & alignMask;
      RD_SEPC: csrRdata = epcQ[EPC_S] & alignMask;
      RD_DPC:  csrRdata = epcQ[EPC_D] & alignMask;
      default: csrRdata = '0;
    endcase
  end

  assert_isa_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.isaHit && !csrWdata[BIT_C] && curPcBit1) |=> $stable(isaQ));

  assert_fd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.wrIsa && !csrWdata[BIT_F]) |=> !isaQ[BIT_D]);

endmodule

// File: rtl/ext_align_csr.sv
module ext_align_csr
  import ext_align_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter int               ADDR_W    = 12,
  parameter logic [XLEN-1:0]  RESET_ISA = XLEN'(32'h4014112D)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              csrWe,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  input  logic [XLEN-1:0]   curPc,
  input  logic              trapValid,
  input  logic [1:0]        trapSel,
  input  logic [XLEN-1:0]   trapPc,
  input  logic [XLEN-1:0]   jumpPc,
  output logic [XLEN-1:0]   jumpPcMasked,
  input  logic [XLEN-1:0]   candPc,
  output logic              candMisaligned,
  output logic [XLEN-1:0]   alignMask
);

  csr_strobe_t strobes;

  ext_align_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .csrAddr         (csrAddr),
    .csrWe           (csrWe),
    .wdataCompressed (csrWdata[BIT_C]),
    .curPcBit1       (curPc[1]),
    .trapValid       (trapValid),
    .trapSel         (trapSel),
    .strobes         (strobes)
  );

  ext_align_dp #(.XLEN(XLEN), .RESET_ISA(RESET_ISA)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobes        (strobes),
    .csrWdata       (csrWdata),
    .curPcBit1      (curPc[1]),
    .trapPc         (trapPc),
    .jumpPc         (jumpPc),
    .candPc         (candPc),
    .csrRdata       (csrRdata),
    .alignMask      (alignMask),
    .jumpPcMasked   (jumpPcMasked),
    .candMisaligned (candMisaligned)
  );

  assert_cand_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    candMisaligned |-> (candPc[1] && !alignMask[1]));

  assert_jump_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jumpPcMasked[1] |-> (alignMask[1] && jumpPc[1]));

endmodule

// File: tb/ext_align_csr_tb.sv
`timescale 1ns/1ps
module ext_align_csr_tb;

  localparam int XLEN = 32;
  localparam logic [11:0] A_ISA = 12'h301, A_MEPC = 12'h341,
                          A_SEPC = 12'h141, A_DPC = 12'h7B1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] csrAddr = '0;
  logic csrWe = 1'b0;
  logic [XLEN-1:0] csrWdata = '0, csrRdata, curPc = '0, trapPc = '0;
  logic [XLEN-1:0] jumpPc = '0, jumpPcMasked, candPc = '0, alignMask;
  logic trapValid = 1'b0, candMisaligned;
  logic [1:0] trapSel = '0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_align_csr u_dut (
    .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .curPc(curPc),
    .trapValid(trapValid), .trapSel(trapSel), .trapPc(trapPc),
    .jumpPc(jumpPc), .jumpPcMasked(jumpPcMasked), .candPc(candPc),
    .candMisaligned(candMisaligned), .alignMask(alignMask)
  );

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csrWrite(logic [11:0] a, logic [XLEN-1:0] d);
    @(negedge clk);
    csrAddr = a; csrWdata = d; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  task automatic csrRead(logic [11:0] a, output logic [XLEN-1:0] d);
    @(negedge clk);
    csrAddr = a;
    #1 d = csrRdata;
  endtask

  task automatic test_reset;
    logic [XLEN-1:0] v;
    csrRead(A_ISA, v);  check("R1 isa reset", v, 32'h4014112D);
    csrRead(A_MEPC, v); check("R1 mepc reset", v, 0);
    csrRead(A_SEPC, v); check("R1 sepc reset", v, 0);
    csrRead(A_DPC, v);  check("R1 dpc reset", v, 0);
    check("R2 mask with C on", alignMask, 32'hFFFF_FFFF);
  endtask

  task automatic test_epc_write;
    logic [XLEN-1:0] v;
    csrWrite(A_MEPC, 32'h1000_0007);
    csrWrite(A_SEPC, 32'h0000_0022);
    csrWrite(A_DPC,  32'hABCD_0003);
    csrRead(A_MEPC, v); check("R6 mepc bit0", v, 32'h1000_0006);
    csrRead(A_SEPC, v); check("R6 sepc", v, 32'h0000_0022);
    csrRead(A_DPC, v);  check("R6 dpc bit0", v, 32'hABCD_0002);
  endtask

  task automatic test_guarded_disable;
    logic [XLEN-1:0] v;
    curPc = 32'h0000_0102;
    csrWrite(A_ISA, 32'h0000_0001);
    csrRead(A_ISA, v); check("R3 isa write dropped", v, 32'h4014112D);
    check("R3 mask unchanged", alignMask, 32'hFFFF_FFFF);
  endtask

  task automatic test_disable_and_mask;
    logic [XLEN-1:0] v;
    curPc = 32'h0000_0100;
    csrWrite(A_ISA, 32'h4014_1109);
    csrRead(A_ISA, v);  check("R4 D cleared without F", v, 32'h4014_1101);
    check("R2 mask with C off", alignMask, 32'hFFFF_FFFD);
    csrRead(A_MEPC, v); check("R5 mepc masked", v, 32'h1000_0004);
    csrRead(A_SEPC, v); check("R5 sepc masked", v, 32'h0000_0020);
    csrRead(A_DPC, v);  check("R5 dpc masked", v, 32'hABCD_0000);
    jumpPc = 32'h0000_0206; #1;
    check("R8 jump masked C off", jumpPcMasked, 32'h0000_0204);
    candPc = 32'h0000_0302; #1;
    check("R9 misaligned C off", {31'b0, candMisaligned}, 1);
    candPc = 32'h0000_0300; #1;
    check("R9 aligned C off", {31'b0, candMisaligned}, 0);
  endtask

  task automatic test_reenable;
    logic [XLEN-1:0] v;
    curPc = 32'h0000_0102;
    csrWrite(A_ISA, 32'h4014_112D);
    csrRead(A_ISA, v);  check("R3 enabling allowed at pc[1]", v, 32'h4014_112D);
    csrRead(A_MEPC, v); check("R5 mepc bit1 returns", v, 32'h1000_0006);
    csrRead(A_SEPC, v); check("R5 sepc bit1 returns", v, 32'h0000_0022);
    #1;
    check("R8 jump C on", jumpPcMasked, 32'h0000_0206);
    candPc = 32'h0000_0302; #1;
    check("R9 no flag C on", {31'b0, candMisaligned}, 0);
  endtask

  task automatic test_trap;
    logic [XLEN-1:0] v;
    @(negedge clk);
    trapValid = 1'b1; trapSel = 2'd1; trapPc = 32'h0000_3333;
    csrAddr = A_SEPC; csrWdata = 32'h0000_4444; csrWe = 1'b1;
    @(negedge clk);
    csrWe = 1'b0; trapSel = 2'd2; trapPc = 32'h0000_0055;
    @(negedge clk);
    trapSel = 2'd3; trapPc = 32'hFFFF_FFFF;
    @(negedge clk);
    trapValid = 1'b0;
    csrRead(A_SEPC, v); check("R7 trap wins over write", v, 32'h0000_3332);
    csrRead(A_DPC, v);  check("R7 dpc trap load", v, 32'h0000_0054);
    csrRead(A_MEPC, v); check("R7 sel 3 loads none", v, 32'h1000_0006);
  endtask

  task automatic test_unmapped;
    logic [XLEN-1:0] v;
    csrWrite(12'h123, 32'hFFFF_FFFF);
    csrRead(12'h123, v); check("R10 unmapped reads zero", v, 0);
    csrRead(A_ISA, v);   check("R10 isa untouched", v, 32'h4014_112D);
    csrRead(A_MEPC, v);  check("R10 mepc untouched", v, 32'h1000_0006);
  endtask

  task automatic test_other_bits;
    logic [XLEN-1:0] v;
    curPc = 32'h0000_0100;
    csrWrite(A_ISA, 32'h0000_0FFF);
    csrRead(A_ISA, v); check("R4 bits kept with F", v, 32'h0000_0FFF);
    csrWrite(A_ISA, 32'h0000_0FDF);
    csrRead(A_ISA, v); check("R4 D cleared, rest kept", v, 32'h0000_0FD7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_epc_write();
    test_guarded_disable();
    test_disable_and_mask();
    test_reenable();
    test_trap();
    test_unmapped();
    test_other_bits();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule